// File: doc/BRIEF.md
# Four-Plane Graphics Memory Datapath

This block sits between a byte-wide CPU bus and four byte-wide planes of graphics memory that share one address. A CPU read fetches the byte at one offset from all four planes at once, keeps the four bytes in per-plane latches and returns one of them. A CPU write builds a new byte for each plane and stores it where that plane is enabled. The new byte comes from the CPU data, a per-plane constant colour, or the latched bytes. It then passes through a logic function against the latch and a bit-wise mask.

Software sets up the datapath through an index/data configuration port. The CPU sees a 64 KiB window starting at `WIN_BASE`. Each plane holds `2**OFS_W` bytes, and window offsets wrap modulo that depth. The controller tracks read responses with two states. `ST_IDLE` means no response is pending. `ST_RESP` means `rd_valid` is high with the result of the previous cycle's read. An in-window read moves either state to `ST_RESP` (transition `T_READ`), and any other cycle returns to `ST_IDLE` (transition `T_DONE`).

Top module: `vga_planar_dp`

## Requirements
- R1: After reset, `rd_valid` and `unsup_flag` are 0. Every configuration register is 0 except the bit mask, which is 0xFF, so a write with only the plane-enable mask changed stores the CPU byte unchanged into the enabled planes.
- R2: An in-window read (`cpu_req`=1, `cpu_we`=0) sets `rd_valid` in the next cycle. On the same edge it loads latch n with plane n at offset (`cpu_addr` − `WIN_BASE`) mod `2**OFS_W`, for n = 0..3.
- R3: When read mode is 0, `rd_data` is the byte from the plane numbered by bits 1:0 of the read-plane register (index 3).
- R4: When mode register (index 4) bit 3 is 1, a read returns 0x00, still loads the latches, and sets the sticky `unsup_flag`.
- R5: In write mode 0 (mode bits 1:0 = 00), bits 4:3 of the function register (index 2) pick the logic applied to the source and the latch: 00 source, 01 AND, 10 OR, 11 XOR.
- R6: In write mode 0, the CPU byte is rotated right by function-register bits 2:0 before it is used as a source.
- R7: In write mode 0, a plane whose bit is set in the constant-enable register (index 1) uses its constant-colour bit (index 0) copied to all 8 bits as the source instead of the CPU byte.
- R8: Where a bit of the bit-mask register (index 5) is 0, the stored bit equals the latch bit. Where it is 1, the stored bit is the function result.
- R9: In write mode 1, each plane receives its latch byte unchanged.
- R10: In write mode 2, plane n's source is CPU data bit n copied to all 8 bits, followed by the same function and bit-mask stages.
- R11: Plane n is written only when bit n of the plane-enable register (index 6) is 1. The other planes keep their contents.
- R12: In write mode 3, no plane is written and the sticky `unsup_flag` is set. The flag stays at 1 until reset.
- R13: A request whose address lies outside [`WIN_BASE`, `WIN_BASE`+0x10000) produces no read response and writes no plane.
- R14: A configuration write takes effect on its clock edge. Index 7 selects no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 8 | Read result |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration register data |
| unsup_flag | output | 1 | Sticky flag for an unsupported read or write mode |

## Verification
The assertions assume that `cpu_req` lasts one cycle per access. They compare each response and plane-write strobe with the request and the configuration that were in force on the same edge, so they take it as given that a configuration write does not land on the same edge as a CPU access that relies on it. The bench keeps to this by using tasks that issue each configuration write and each CPU access in a cycle of its own. Between those cycles the bench keeps its own model of the planes and the latches, and it always reloads the latches with an explicit read before a write that uses them.

// File: rtl/vga_dp_pkg.sv
package vga_dp_pkg;

    localparam int NPLANES = 4;
    localparam int PSEL_W  = $clog2(NPLANES);

    typedef logic [7:0] byte_t;

    // configuration register indices
    localparam logic [2:0] IDX_CCOLOR  = 3'd0;
    localparam logic [2:0] IDX_CENABLE = 3'd1;
    localparam logic [2:0] IDX_FUNC    = 3'd2;
    localparam logic [2:0] IDX_RPLANE  = 3'd3;
    localparam logic [2:0] IDX_MODE    = 3'd4;
    localparam logic [2:0] IDX_BMASK   = 3'd5;
    localparam logic [2:0] IDX_PENABLE = 3'd6;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_AND  = 2'd1,
        FN_OR   = 2'd2,
        FN_XOR  = 2'd3
    } alu_fn_e;

    typedef enum logic [1:0] {
        WM_MERGE  = 2'd0,
        WM_COPY   = 2'd1,
        WM_EXPAND = 2'd2,
        WM_RSVD   = 2'd3
    } wmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    typedef struct packed {
        logic [NPLANES-1:0] ccolor;
        logic [NPLANES-1:0] cenable;
        alu_fn_e            fn;
        logic [2:0]         rot;
        logic [PSEL_W-1:0]  rplane;
        logic               rmode;
        wmode_e             wmode;
        byte_t              bmask;
        logic [NPLANES-1:0] penable;
    } cfg_t;

    function automatic byte_t ror8(input byte_t d, input logic [2:0] n);
        logic [15:0] dd;
        dd = {d, d} >> n;
        return dd[7:0];
    endfunction

endpackage

// File: rtl/vga_cfg_regs.sv
module vga_cfg_regs
    import vga_dp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_idx,
    input  logic [7:0] cfg_wdata,
    output cfg_t       cfg_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q         <= '0;
            cfg_q.fn      <= FN_PASS;
            cfg_q.wmode   <= WM_MERGE;
            cfg_q.bmask   <= 8'hFF;
        end else if (cfg_wr) begin
            case (cfg_idx)
                IDX_CCOLOR:  cfg_q.ccolor  <= cfg_wdata[NPLANES-1:0];
                IDX_CENABLE: cfg_q.cenable <= cfg_wdata[NPLANES-1:0];
                IDX_FUNC: begin
                    cfg_q.rot <= cfg_wdata[2:0];
                    cfg_q.fn  <= alu_fn_e'(cfg_wdata[4:3]);
                end
                IDX_RPLANE:  cfg_q.rplane  <= cfg_wdata[PSEL_W-1:0];
                IDX_MODE: begin
                    cfg_q.wmode <= wmode_e'(cfg_wdata[1:0]);
                    cfg_q.rmode <= cfg_wdata[3];
                end
                IDX_BMASK:   cfg_q.bmask   <= cfg_wdata;
                IDX_PENABLE: cfg_q.penable <= cfg_wdata[NPLANES-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vga_plane_store.sv
module vga_plane_store
    import vga_dp_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic                     clk,
    input  logic [NPLANES-1:0]       we,
    input  logic [OFS_W-1:0]         ofs,
    input  logic [NPLANES-1:0][7:0]  wdata,
    output logic [NPLANES-1:0][7:0]  rdata
);

    localparam int DEPTH = 2 ** OFS_W;

    for (genvar g = 0; g < NPLANES; g++) begin : g_plane
        byte_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[ofs] <= wdata[g];
        end

        assign rdata[g] = mem[ofs];
    end

endmodule

// File: rtl/vga_write_merge.sv
module vga_write_merge
    import vga_dp_pkg::*;
(
    input  cfg_t                     cfg,
    input  byte_t                    cpu_byte,
    input  logic [NPLANES-1:0][7:0]  latch,
    output logic [NPLANES-1:0][7:0]  result,
    output logic [NPLANES-1:0]       plane_en
);

    byte_t rot_byte;
    assign rot_byte = ror8(cpu_byte, cfg.rot);

    assign plane_en = (cfg.wmode == WM_RSVD) ? '0 : cfg.penable;

    for (genvar g = 0; g < NPLANES; g++) begin : g_lane
        byte_t src;
        byte_t fres;

        always_comb begin
            if (cfg.wmode == WM_EXPAND)
                src = {8{cpu_byte[g]}};
            else if (cfg.cenable[g])
                src = {8{cfg.ccolor[g]}};
            else
                src = rot_byte;

            unique case (cfg.fn)
                FN_PASS: fres = src;
                FN_AND:  fres = src & latch[g];
                FN_OR:   fres = src | latch[g];
                FN_XOR:  fres = src ^ latch[g];
            endcase

            if (cfg.wmode == WM_COPY)
                result[g] = latch[g];
            else
                result[g] = (fres & cfg.bmask) | (latch[g] & ~cfg.bmask);
        end
    end

endmodule

// File: rtl/vga_planar_dp.sv
module vga_planar_dp
    import vga_dp_pkg::*;
#(
    parameter int              AW       = 20,
    parameter int              OFS_W    = 8,
    parameter logic [AW-1:0]   WIN_BASE = 20'hA0000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [7:0]     cpu_wdata,
    output logic           rd_valid,
    output logic [7:0]     rd_data,
    input  logic           cfg_wr,
    input  logic [2:0]     cfg_idx,
    input  logic [7:0]     cfg_wdata,
    output logic           unsup_flag
);

    localparam int            WIN_W  = 16;
    localparam logic [AW:0]   WIN_LO = {1'b0, WIN_BASE};
    localparam logic [AW:0]   WIN_HI = WIN_LO + (AW+1)'(2 ** WIN_W);

    cfg_t                     cfg_q;
    state_e                   state_q, state_d;
    logic [NPLANES-1:0][7:0]  latch_q;
    logic [NPLANES-1:0][7:0]  plane_rd;
    logic [NPLANES-1:0][7:0]  merge_res;
    logic [NPLANES-1:0]       merge_en;
    logic [NPLANES-1:0]       plane_we;
    logic [OFS_W-1:0]         ofs;
    logic                     in_win, rd_acc, wr_acc;
    byte_t                    rd_data_q;
    logic                     flag_q;

    // views of the configuration for the bound checker
    logic                     cfg_rmode;
    logic [1:0]               cfg_wmode;
    logic [NPLANES-1:0]       cfg_penable;
    assign cfg_rmode   = cfg_q.rmode;
    assign cfg_wmode   = cfg_q.wmode;
    assign cfg_penable = cfg_q.penable;

    assign in_win = ({1'b0, cpu_addr} >= WIN_LO) && ({1'b0, cpu_addr} < WIN_HI);
    assign ofs    = OFS_W'(cpu_addr - WIN_BASE);
    assign rd_acc = cpu_req && !cpu_we && in_win;
    assign wr_acc = cpu_req &&  cpu_we && in_win;

    vga_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q)
    );

    vga_write_merge u_merge (
        .cfg      (cfg_q),
        .cpu_byte (cpu_wdata),
        .latch    (latch_q),
        .result   (merge_res),
        .plane_en (merge_en)
    );

    assign plane_we = wr_acc ? merge_en : '0;

    vga_plane_store #(.OFS_W(OFS_W)) u_store (
        .clk   (clk),
        .we    (plane_we),
        .ofs   (ofs),
        .wdata (merge_res),
        .rdata (plane_rd)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: T_READ into ST_RESP, T_DONE back to ST_IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_acc ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_acc ? ST_RESP : ST_IDLE;
        endcase
    end

    // outputs, latches and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q   <= '0;
            rd_data_q <= '0;
            flag_q    <= 1'b0;
        end else begin
            if (rd_acc) begin
                latch_q   <= plane_rd;
                rd_data_q <= cfg_q.rmode ? 8'h00 : plane_rd[cfg_q.rplane];
            end
            if ((rd_acc && cfg_q.rmode) || (wr_acc && cfg_q.wmode == WM_RSVD))
                flag_q <= 1'b1;
        end
    end

    assign rd_valid   = (state_q == ST_RESP);
    assign rd_data    = rd_data_q;
    assign unsup_flag = flag_q;

endmodule

// File: rtl/vga_planar_dp_chk.sv
module vga_planar_dp_chk #(
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic          in_win,
    input logic          cfg_rmode,
    input logic [1:0]    cfg_wmode,
    input logic [NP-1:0] cfg_penable,
    input logic [NP-1:0] plane_we,
    input logic          rd_valid,
    input logic [7:0]    rd_data,
    input logic          unsup_flag
);

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && in_win) |=> rd_valid); // R2

    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cpu_req && !cpu_we && in_win)); // R13

    AST_RMODE1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(cfg_rmode)) |-> (rd_data == 8'h00)); // R4

    AST_RMODE1_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && in_win && cfg_rmode) |=> unsup_flag); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_flag |=> unsup_flag); // R12

    AST_WMODE3_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && in_win && cfg_wmode == 2'b11) |=> unsup_flag); // R12

    AST_WMODE3_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wmode == 2'b11) |-> (plane_we == '0)); // R12

    AST_PLANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_we & ~cfg_penable) == '0); // R11

    AST_OUTSIDE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && cpu_we && in_win) |-> (plane_we == '0)); // R13

endmodule

bind vga_planar_dp vga_planar_dp_chk #(.NP(vga_dp_pkg::NPLANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .in_win      (in_win),
    .cfg_rmode   (cfg_rmode),
    .cfg_wmode   (cfg_wmode),
    .cfg_penable (cfg_penable),
    .plane_we    (plane_we),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .unsup_flag  (unsup_flag)
);

// File: tb/vga_planar_dp_tb_top.sv
module vga_planar_dp_tb_top;

    localparam logic [19:0] BASE = 20'hA0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [19:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        cfg_wr;
    logic [2:0]  cfg_idx;
    logic [7:0]  cfg_wdata;
    logic        unsup_flag;

    always #2 clk = ~clk;

    vga_planar_dp dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .unsup_flag(unsup_flag)
    );

    int n_run  = 0;
    int n_fail = 0;

    // bench model
    logic [7:0] mdl [4][256];
    logic [7:0] lat [4];
    logic [7:0] m_reg [8];

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_reg[5] = 8'hFF;
        for (int p = 0; p < 4; p++) lat[p] = 8'h00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic cfg(input logic [2:0] idx, input logic [7:0] val);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (idx != 3'd7) m_reg[idx] = val;
    endtask

    function automatic logic in_window(input logic [19:0] a);
        return (a >= BASE) && (a < BASE + 20'h10000);
    endfunction

    task automatic rd(input logic [19:0] a, output logic [7:0] d, output logic v);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(negedge clk);
        cpu_req = 1'b0;
        d = rd_data; v = rd_valid;
        if (in_window(a))
            for (int p = 0; p < 4; p++) lat[p] = mdl[p][a[7:0]];
    endtask

    function automatic logic [7:0] exp_byte(input int p, input logic [7:0] d);
        logic [15:0] dd;
        logic [7:0]  src, f;
        dd = {d, d} >> m_reg[2][2:0];
        if (m_reg[4][1:0] == 2'd1) return lat[p];
        if (m_reg[4][1:0] == 2'd2)   src = {8{d[p]}};
        else if (m_reg[1][p])        src = {8{m_reg[0][p]}};
        else                         src = dd[7:0];
        case (m_reg[2][4:3])
            2'd0: f = src;
            2'd1: f = src & lat[p];
            2'd2: f = src | lat[p];
            default: f = src ^ lat[p];
        endcase
        return (f & m_reg[5]) | (lat[p] & ~m_reg[5]);
    endfunction

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        logic [7:0] nb [4];
        for (int p = 0; p < 4; p++) nb[p] = exp_byte(p, d);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        if (in_window(a) && m_reg[4][1:0] != 2'd3)
            for (int p = 0; p < 4; p++)
                if (m_reg[6][p]) mdl[p][a[7:0]] = nb[p];
    endtask

    // read back every plane at one offset (read mode 0 assumed)
    task automatic peek(input logic [7:0] o, input string req);
        logic [7:0] d; logic v;
        for (int p = 0; p < 4; p++) begin
            cfg(3'd3, 8'(p));
            rd(BASE + 20'(o), d, v);
            chk({req, " valid"}, {7'd0, v}, 8'h01);
            chk(req, d, mdl[p][o]);
        end
    endtask

    task automatic load(input logic [7:0] o);
        logic [7:0] d; logic v;
        rd(BASE + 20'(o), d, v);
    endtask

    task automatic t_reset();
        chk("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
        chk("R1 flag", {7'd0, unsup_flag}, 8'h00);
        cfg(3'd6, 8'h0F);
        for (int o = 0; o < 256; o += 16) wr(BASE + 20'(o), 8'(o) ^ 8'h5A);
        wr(BASE + 20'h10, 8'h5A);
        peek(8'h10, "R1");
        chk("R1 literal", mdl[2][8'h10], 8'h5A);
    endtask

    task automatic t_penable();
        for (int p = 0; p < 4; p++) begin
            cfg(3'd6, 8'(1 << p));
            wr(BASE + 20'h20, 8'h11 * 8'(p + 1));
        end
        cfg(3'd6, 8'h05);
        wr(BASE + 20'h21, 8'hC6);
        peek(8'h20, "R11");
        peek(8'h21, "R11");
    endtask

    task automatic t_read_sel();
        logic [7:0] d; logic v;
        cfg(3'd3, 8'd2);
        rd(BASE + 20'h120, d, v);
        chk("R2 alias", d, 8'h33);
        cfg(3'd3, 8'd1);
        rd(BASE + 20'h20, d, v);
        chk("R3 plane1", d, 8'h22);
        cfg(3'd6, 8'h0F);
        cfg(3'd4, 8'h01);
        wr(BASE + 20'h30, 8'h00);
        cfg(3'd4, 8'h00);
        peek(8'h30, "R9 R2 latch copy");
    endtask

    task automatic t_functions();
        for (int fn = 0; fn < 4; fn++) begin
            cfg(3'd2, 8'(fn << 3));
            load(8'h20);
            wr(BASE + 20'(8'h40 + fn), 8'hC3);
            peek(8'(8'h40 + fn), "R5");
        end
        cfg(3'd2, 8'h03);
        load(8'h20);
        wr(BASE + 20'h50, 8'h81);
        peek(8'h50, "R6");
        chk("R6 literal", mdl[0][8'h50], 8'h30);
        cfg(3'd2, 8'h00);
    endtask

    task automatic t_colour_mask();
        cfg(3'd0, 8'h0A);
        cfg(3'd1, 8'h06);
        load(8'h20);
        wr(BASE + 20'h60, 8'h3C);
        peek(8'h60, "R7");
        cfg(3'd1, 8'h00);
        cfg(3'd5, 8'hF0);
        load(8'h20);
        wr(BASE + 20'h70, 8'h0F);
        peek(8'h70, "R8");
        cfg(3'd5, 8'hFF);
        cfg(3'd4, 8'h02);
        cfg(3'd2, 8'h18);
        load(8'h21);
        wr(BASE + 20'h80, 8'h05);
        cfg(3'd4, 8'h00);
        cfg(3'd2, 8'h00);
        peek(8'h80, "R10");
        cfg(3'd7, 8'h00);
        wr(BASE + 20'h81, 8'h77);
        peek(8'h81, "R14 idx7");
    endtask

    task automatic t_window();
        logic [7:0] d; logic v;
        rd(20'hB0000, d, v);
        chk("R13 high rd", {7'd0, v}, 8'h00);
        rd(20'h9FFFF, d, v);
        chk("R13 low rd", {7'd0, v}, 8'h00);
        wr(20'h9FF80, 8'hEE);
        wr(20'hB0080, 8'hEE);
        peek(8'h80, "R13");
    endtask

    task automatic t_unsupported();
        cfg(3'd4, 8'h03);
        wr(BASE + 20'h90, 8'hAB);
        chk("R12 flag", {7'd0, unsup_flag}, 8'h01);
        cfg(3'd4, 8'h00);
        peek(8'h90, "R12 no write");
        chk("R12 sticky", {7'd0, unsup_flag}, 8'h01);
        do_reset();
        chk("R1 flag clear", {7'd0, unsup_flag}, 8'h00);
        cfg(3'd6, 8'h0F);
        cfg(3'd4, 8'h08);
        begin
            logic [7:0] d; logic v;
            rd(BASE + 20'h20, d, v);
            chk("R4 data", d, 8'h00);
            chk("R4 valid", {7'd0, v}, 8'h01);
            chk("R4 flag", {7'd0, unsup_flag}, 8'h01);
        end
        cfg(3'd4, 8'h01);
        wr(BASE + 20'hA0, 8'h00);
        cfg(3'd4, 8'h00);
        peek(8'hA0, "R4 latch");
    endtask

    initial begin
        cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
        cfg_wr = 0; cfg_idx = '0; cfg_wdata = '0;
        for (int p = 0; p < 4; p++)
            for (int o = 0; o < 256; o++) mdl[p][o] = 8'h00;
        @(negedge clk);
        do_reset();
        t_reset();
        t_penable();
        t_read_sel();
        t_functions();
        t_colour_mask();
        t_window();
        t_unsupported();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule